// File: doc/BRIEF.md
# Long Duration and Periodic Interrupt Timer

This is a byte-addressed timer peripheral. It holds a 32-bit up-counter, a 32-bit read holding register and one status and control byte. The count advances on ticks that come from outside the system clock domain. There are two tick sources. The fast source is divided by four inside the block, and the slow source (nominally 32.768 kHz) is used as it is. Every tick input is synchronised and edge-detected in the system clock domain, so the count moves by at most one per clock.

With the rate field at zero, the counter runs freely over the full 32-bit range and raises the interrupt flag when it wraps to zero. Any other rate code turns the block into a periodic timer. The count then returns to zero after a fixed terminal value, and each return raises the flag. Software reads the count coherently by reading the low byte first, because that read captures all 32 bits at once. Software acknowledges an interrupt by writing the status byte back with the flag bit cleared.

The counter and the holding register have their own power-on reset. The ordinary reset only returns the control state to idle, so a long count survives a warm reset.

Top module: `ldt_timer`

## Requirements
- R1: Offsets 0 to 3 hold the counter bytes, least significant at offset 0, and offset 4 is the status and control byte. Read data appears on `reg_rdata` at the clock edge that samples `reg_rd` and holds until the next read.
- R2: A read of offset 0 copies the live 32-bit count into the holding register and returns bits 7:0 of that copy. Reads of offsets 1 to 3 return the matching holding byte and leave the holding register unchanged.
- R3: A write to offset N (0 to 3) replaces counter bits 8N+7:8N and no other bits. A counter write takes precedence over a tick in the same cycle.
- R4: `por_n` low clears the counter, the holding register and the control byte. `rst_n` low clears the control byte to 0x00 and leaves the counter and the holding register unchanged.
- R5: With run=1 and clock select=1, each rising edge on `tick_slow` adds one to the count. The new value is in place at the third rising clock edge after the input rises.
- R6: With run=1 and clock select=0, every fourth rising edge on `tick_fast` adds one to the count. The divide-by-four phase starts at zero after reset.
- R7: With run=0, tick edges leave the counter unchanged.
- R8: With rate code 000, an advance from FFFFFFFFh gives 00000000h and sets the interrupt flag.
- R9: Rate codes 001 to 111 select terminal counts 9999, 4999, 1999, 999, 499, 199 and 99. An advance from the terminal count gives 0 and sets the flag.
- R10: Status byte layout: bit 0 is run, bit 1 is clock select, bits 4:2 are the rate code, bits 6:5 read as 0 and bit 7 is the interrupt flag. Writing 0 to bit 7 clears the flag and writing 1 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R11: `irq` is high exactly when the interrupt flag and run are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | Warm reset, active low, clears control only |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tick_fast | input | 1 | Fast tick source, divided by four inside the block |
| tick_slow | input | 1 | Slow tick source |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due one clock edge after the read strobe. The scoreboard queues the expected byte when the strobe is driven and compares it at the falling edge after that sampling edge. A tick edge reaches the counter three rising edges after the input rises: two synchroniser flops, then the counter register. The bench places a low-byte read on exactly that third edge to confirm that the snapshot still holds the old count, and that the next read returns the new one. A status write is placed on the same edge to check that a wrap wins over a clear. The flag and `irq` follow the advancing edge with no extra delay, and they are checked only after the tick pulse task has let four edges pass.

// File: rtl/ldt_pkg.sv
package ldt_pkg;

   typedef struct packed {
      logic       flag;
      logic [1:0] rsvd;
      logic [2:0] rate;
      logic       slow_sel;
      logic       run;
   } ctl_t;

   localparam logic [2:0] RATE_FREE = 3'd0;

   function automatic logic [31:0] term_of(input logic [2:0] code);
      case (code)
         3'd1:    term_of = 32'd9999;
         3'd2:    term_of = 32'd4999;
         3'd3:    term_of = 32'd1999;
         3'd4:    term_of = 32'd999;
         3'd5:    term_of = 32'd499;
         3'd6:    term_of = 32'd199;
         3'd7:    term_of = 32'd99;
         default: term_of = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/ldt_tick_sync.sv
module ldt_tick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ldt_tick_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], tick_in};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ldt_prescale.sv
module ldt_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pulse,
   output logic out
);
   generate
      if (DIV < 1) begin : g_bad
         $error("ldt_prescale: DIV must be at least 1");
      end else if (DIV == 1) begin : g_bypass
         assign out = en & pulse;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           ph_q <= '0;
            else if (en && pulse) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
         end
         assign out = en & pulse & (ph_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/ldt_count.sv
module ldt_count #(
   parameter int CNT_W = 32,
   localparam int NB   = CNT_W / 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             adv,
   input  logic             periodic,
   input  logic [CNT_W-1:0] term,
   input  logic [NB-1:0]    wr_be,
   input  logic [7:0]       wdata,
   input  logic             snap,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] hold,
   output logic             wrap
);
   logic             wr_any;
   logic             at_top;
   logic [CNT_W-1:0] nxt;
   logic [7:0]       byte_q [NB];

   assign wr_any = |wr_be;
   assign at_top = (periodic && cnt == term) || (cnt == '1);
   assign nxt    = at_top ? '0 : cnt + 1'b1;
   assign wrap   = adv & at_top & ~wr_any;

   generate
      for (genvar i = 0; i < NB; i++) begin : g_lane
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                byte_q[i] <= '0;
            else if (wr_be[i])         byte_q[i] <= wdata;
            else if (!wr_any && adv)   byte_q[i] <= nxt[8*i +: 8];
         end
         assign cnt[8*i +: 8] = byte_q[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    hold <= '0;
      else if (snap) hold <= cnt;
   end
endmodule

// File: rtl/ldt_timer.sv
module ldt_timer #(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FAST_DIV    = 4,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              tick_fast,
   input  logic              tick_slow,
   output logic              irq
);
   import ldt_pkg::*;

   localparam int NBYTES = CNT_W / 8;
   localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(NBYTES);

   generate
      if (CNT_W % 8 != 0 || CNT_W < 16) begin : g_bad_w
         $error("ldt_timer: CNT_W must be a multiple of 8 and at least 16");
      end
      if ((1 << ADDR_W) <= NBYTES) begin : g_bad_a
         $error("ldt_timer: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic             rst_all_n;
   ctl_t             ctl_q;
   logic [CNT_W-1:0] cnt_q, hold_q;
   logic [NBYTES-1:0] wr_be;
   logic             wr_any, ctl_wr, snap, wrap;
   logic             fast_rise, slow_rise, fast_adv, adv;

   assign rst_all_n = rst_n & por_n;

   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_dec
         assign wr_be[i] = reg_wr && (reg_addr == ADDR_W'(i));
      end
   endgenerate

   assign wr_any = |wr_be;
   assign ctl_wr = reg_wr && (reg_addr == CTRL_OFS);
   assign snap   = reg_rd && (reg_addr == '0);

   ldt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync_fast (
      .clk(clk), .rst_n(rst_all_n), .tick_in(tick_fast), .rise(fast_rise));
   ldt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync_slow (
      .clk(clk), .rst_n(rst_all_n), .tick_in(tick_slow), .rise(slow_rise));

   ldt_prescale #(.DIV(FAST_DIV)) u_pre (
      .clk(clk), .rst_n(rst_all_n),
      .en(ctl_q.run & ~ctl_q.slow_sel), .pulse(fast_rise), .out(fast_adv));

   assign adv = ctl_q.run & (ctl_q.slow_sel ? slow_rise : fast_adv);

   ldt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .por_n(por_n), .adv(adv),
      .periodic(ctl_q.rate != RATE_FREE),
      .term(CNT_W'(term_of(ctl_q.rate))),
      .wr_be(wr_be), .wdata(reg_wdata), .snap(snap),
      .cnt(cnt_q), .hold(hold_q), .wrap(wrap));

   // control byte: wrap sets the flag, a written 0 in bit 7 clears it
   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n) begin
         ctl_q <= '0;
      end else begin
         if (ctl_wr) begin
            ctl_q.run      <= reg_wdata[0];
            ctl_q.slow_sel <= reg_wdata[1];
            ctl_q.rate     <= reg_wdata[4:2];
         end
         if (wrap)        ctl_q.flag <= 1'b1;
         else if (ctl_wr) ctl_q.flag <= ctl_q.flag & reg_wdata[7];
      end
   end

   logic [7:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (reg_addr == CTRL_OFS) rd_mux = ctl_q;
      for (int i = 0; i < NBYTES; i++) begin
         if (reg_addr == ADDR_W'(i)) rd_mux = (i == 0) ? cnt_q[7:0] : hold_q[8*i +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n)  reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   assign irq = ctl_q.flag & ctl_q.run;
endmodule

// File: rtl/ldt_timer_chk.sv
module ldt_timer_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_all_n,
   input logic             run,
   input logic [2:0]       rate,
   input logic             flag,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] hold,
   input logic             adv,
   input logic             wr_any,
   input logic             ctl_wr,
   input logic [7:0]       wdata,
   input logic             snap,
   input logic             wrap,
   input logic             irq
);
   p_hold_snap_r2: assert property (@(posedge clk) disable iff (!rst_all_n)
      snap |=> hold == $past(cnt));

   p_stopped_r7: assert property (@(posedge clk) disable iff (!rst_all_n)
      (!run && !wr_any) |=> $stable(cnt));

   p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_all_n)
      (!wr_any && !wrap) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

   p_free_wrap_r8: assert property (@(posedge clk) disable iff (!rst_all_n)
      (rate == 3'd0 && cnt == '1 && adv && !wr_any) |=> (cnt == '0 && flag));

   p_term99_r9: assert property (@(posedge clk) disable iff (!rst_all_n)
      (rate == 3'd7 && cnt == CNT_W'(99) && adv && !wr_any) |=> (cnt == '0 && flag));

   p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_all_n)
      (ctl_wr && !wdata[7] && !wrap) |=> !flag);

   p_wrap_irq_r11: assert property (@(posedge clk) disable iff (!rst_all_n)
      (wrap && !(ctl_wr && !wdata[0])) |=> irq);
endmodule

bind ldt_timer ldt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_all_n(rst_all_n), .run(ctl_q.run), .rate(ctl_q.rate),
   .flag(ctl_q.flag), .cnt(cnt_q), .hold(hold_q), .adv(adv), .wr_any(wr_any),
   .ctl_wr(ctl_wr), .wdata(reg_wdata), .snap(snap), .wrap(wrap), .irq(irq));

// File: tb/sim_ldt_timer.sv
module sim_ldt_timer;
   logic       clk = 0;
   logic       por_n = 0, rst_n = 0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 0, reg_rd = 0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       tick_fast = 0, tick_slow = 0;
   logic       irq;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_seen = 0;

   always #5 clk = ~clk;

   ldt_timer u0 (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .tick_fast(tick_fast), .tick_slow(tick_slow),
      .irq(irq));

   task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // monitor: compare read data one edge after the strobe
   always @(posedge clk) rd_seen <= reg_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check({24'd0, reg_rdata}, {24'd0, e}, t);
      end
   end

   task automatic do_read(input logic [2:0] a, input logic [7:0] e, input string t);
      reg_addr = a; reg_rd = 1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic do_write(input logic [2:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(posedge clk); @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic wr_cnt(input logic [31:0] v);
      for (int i = 0; i < 4; i++) do_write(3'(i), v[8*i +: 8]);
   endtask

   task automatic rd_cnt(input logic [31:0] v, input string t);
      for (int i = 0; i < 4; i++) do_read(3'(i), v[8*i +: 8], t);
   endtask

   task automatic pulse_slow(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick_slow = 1;
         repeat (2) @(negedge clk);
         tick_slow = 0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic pulse_fast(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick_fast = 1;
         repeat (2) @(negedge clk);
         tick_fast = 0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic finish_run;
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] terms [7];
      terms = '{9999, 4999, 1999, 999, 499, 199, 99};
      repeat (3) @(negedge clk);
      por_n = 1; rst_n = 1;
      @(negedge clk);
      // R4 reset state
      do_read(3'd4, 8'h00, "R4 ctrl after power-on");
      rd_cnt(32'h0, "R4 count after power-on");
      check({31'd0, irq}, 0, "R11 irq after reset");

      // R1 / R3 byte lanes
      wr_cnt(32'h1122_3344);
      rd_cnt(32'h1122_3344, "R1 little-endian count");
      do_write(3'd2, 8'hAA);
      rd_cnt(32'h11AA_3344, "R3 single byte write");

      // R2 holding register
      do_write(3'd0, 8'h55);
      do_write(3'd3, 8'h77);
      do_read(3'd3, 8'h11, "R2 hold unchanged by byte reads");
      do_read(3'd0, 8'h55, "R2 low byte snapshot");
      do_read(3'd3, 8'h77, "R2 hold after snapshot");

      // R7 stopped
      pulse_slow(3);
      rd_cnt(32'h77AA_3355, "R7 ticks ignored when stopped");

      // R5 slow ticks
      wr_cnt(32'h0);
      do_write(3'd4, 8'h03);
      pulse_slow(5);
      rd_cnt(32'd5, "R5 slow tick count");
      @(negedge clk) tick_slow = 1;
      repeat (2) @(negedge clk);
      do_read(3'd0, 8'd5, "R5 count not yet advanced at third edge snapshot");
      do_read(3'd0, 8'd6, "R5 count advanced after third edge");
      tick_slow = 0;
      repeat (2) @(negedge clk);

      // R6 fast ticks divided by four
      do_write(3'd4, 8'h01);
      pulse_fast(3);
      rd_cnt(32'd6, "R6 three fast ticks no advance");
      pulse_fast(1);
      rd_cnt(32'd7, "R6 fourth fast tick advances");
      pulse_fast(4);
      rd_cnt(32'd8, "R6 next four fast ticks");

      // R8 free-running wrap
      do_write(3'd4, 8'h00);
      wr_cnt(32'hFFFF_FFFE);
      do_write(3'd4, 8'h03);
      pulse_slow(1);
      do_read(3'd4, 8'h03, "R8 no flag before wrap");
      check({31'd0, irq}, 0, "R11 irq low before wrap");
      pulse_slow(1);
      do_read(3'd4, 8'h83, "R8 flag after wrap");
      check({31'd0, irq}, 1, "R11 irq high with flag and run");
      rd_cnt(32'h0, "R8 count zero after wrap");

      // R10 / R11 flag write semantics
      do_write(3'd4, 8'h83);
      do_read(3'd4, 8'h83, "R10 writing 1 keeps flag");
      do_write(3'd4, 8'h82);
      do_read(3'd4, 8'h82, "R10 flag kept when stopping");
      check({31'd0, irq}, 0, "R11 irq low when stopped");
      do_write(3'd4, 8'h03);
      do_read(3'd4, 8'h03, "R10 writing 0 clears flag");
      check({31'd0, irq}, 0, "R11 irq low after clear");
      do_write(3'd4, 8'hFF);
      do_read(3'd4, 8'h1F, "R10 reserved bits read zero");

      // R9 periodic terminals
      for (int c = 1; c <= 7; c++) begin
         do_write(3'd4, 8'((c << 2) | 2));
         wr_cnt(terms[c-1] - 1);
         do_write(3'd4, 8'((c << 2) | 3));
         pulse_slow(1);
         do_read(3'd4, 8'((c << 2) | 3), $sformatf("R9 code %0d no flag at terminal", c));
         rd_cnt(terms[c-1], $sformatf("R9 code %0d at terminal", c));
         pulse_slow(1);
         do_read(3'd4, 8'(8'h80 | (c << 2) | 3), $sformatf("R9 code %0d flag on wrap", c));
         rd_cnt(32'h0, $sformatf("R9 code %0d zero after terminal", c));
      end

      // R10 wrap in the same cycle as a clearing write
      do_write(3'd4, 8'h9E);
      wr_cnt(32'd99);
      do_write(3'd4, 8'h9F);
      @(negedge clk) tick_slow = 1;
      repeat (2) @(negedge clk);
      do_write(3'd4, 8'h1F);
      tick_slow = 0;
      repeat (2) @(negedge clk);
      do_read(3'd4, 8'h9F, "R10 wrap wins over clear");

      // R4 warm reset keeps counter and holding register
      do_write(3'd4, 8'h00);
      wr_cnt(32'h1234_5678);
      do_read(3'd0, 8'h78, "R4 snapshot before warm reset");
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      do_read(3'd1, 8'h56, "R4 hold kept over warm reset");
      do_read(3'd4, 8'h00, "R4 ctrl cleared by warm reset");
      rd_cnt(32'h1234_5678, "R4 count kept over warm reset");
      por_n = 0;
      repeat (2) @(negedge clk);
      por_n = 1;
      @(negedge clk);
      do_read(3'd2, 8'h00, "R4 hold cleared by power-on");
      rd_cnt(32'h0, "R4 count cleared by power-on");

      finish_run();
   end
endmodule